// File: doc/BRIEF.md
# Oversampled Serial Receiver with Character Queue

This block receives asynchronous serial characters on a single line. A baud generator outside the block supplies a tick at sixteen times the bit rate. The receiver waits for a falling edge and confirms the start bit at mid-bit. It then recovers each data bit by a majority vote over three samples taken around the middle of the bit, and checks the stop bit. Each finished character goes into a two-entry queue, together with its ninth bit and its framing-error flag. The host sees the entry at the head of the queue on the read outputs and removes it with a one-cycle read strobe.

Two enables gate reception: a port enable, which also flushes the queue when it is low, and a continuous-receive enable. A character that finishes while the queue is full sets a sticky overrun flag. The flag stops all further reception until the continuous-receive enable is dropped. An idle output shows when no character is being received. An interrupt request follows data availability, masked by an interrupt enable.

Top module: `serial_rx_fifo`

## Requirements
- R1: A frame is a low start bit, then the data bits with the least significant bit first, then a stop bit. In 8-bit mode (`nine_bit`=0) the eight data bits appear on `rd_data` and `rd_bit9` reads 0.
- R2: With `nine_bit`=1 a ninth bit is received after the eight data bits. It is presented on `rd_bit9`, separate from the byte on `rd_data`.
- R3: Each bit is sampled on the ticks where the in-bit tick count is 7, 8 and 9, and the value held by at least two of the three samples is taken. One disturbed sample does not change the received bit.
- R4: If the start bit votes high at mid-bit, it is treated as a glitch. No character is stored, and `idle` returns to 1 before the bit ends.
- R5: A stop bit that votes low stores the character with its framing flag set, and `rd_ferr` reads 1 while that entry is at the head. A new start needs a high-to-low transition of the line, so a line held low after the stop bit starts nothing.
- R6: The queue holds two entries. `data_avail` is 1 while it is non-empty. A one-cycle `rd_pop` removes the head entry, in arrival order. A pop while the queue is empty has no effect. With the queue empty, `rd_data`, `rd_bit9` and `rd_ferr` read 0.
- R7: A character that completes while the queue is full, with no pop in that cycle, is discarded, sets `ovr_err` and leaves the stored entries unchanged. A pop in the same cycle as completion frees a slot, so the character is stored and `ovr_err` stays 0.
- R8: While `ovr_err` is 1, no new frame is received. `ovr_err` stays 1 until `rx_en` or `port_en` goes low, which clears it.
- R9: Reception requires `port_en`=1 and `rx_en`=1. With `port_en`=0 the queue is emptied. With `rx_en`=0 and `port_en`=1 the stored entries are kept.
- R10: `irq` equals `data_avail` AND `int_en`.
- R11: `idle` is 1 when no frame is in progress. It goes to 0 once a start edge is seen and returns to 1 at the stop-bit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idles high |
| port_en | input | 1 | Serial port enable; low flushes the queue |
| rx_en | input | 1 | Continuous receive enable; low clears overrun |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| int_en | input | 1 | Interrupt enable |
| rd_pop | input | 1 | Read strobe, removes the head entry |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing flag of the head entry |
| data_avail | output | 1 | Queue not empty |
| ovr_err | output | 1 | Sticky overrun flag |
| idle | output | 1 | No frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
A host pop and the storing of a new character can land in the same clock cycle while the queue holds two entries. The bench provokes this by filling the queue and then sending a third frame, raising `rd_pop` on exactly the tick that carries the stop-bit decision. It judges the outcome by checking three things: `ovr_err` stays clear, the head becomes the second character, and the third character follows it in order. A separate run without the coinciding pop must discard the third character and raise the overrun flag.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       port_en,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       int_en,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rd_ferr,
  output logic       data_avail,
  output logic       ovr_err,
  output logic       idle,
  output logic       irq
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW  = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [1:0]    vs;
  logic [8:0]    sh;
  logic          rx_m, rx_s, rx_q;

  logic [9:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] fill;

  wire run     = port_en & rx_en;
  wire fall    = rx_q & ~rx_s;
  wire decide  = tick && (cnt == CW'(MID + 1));
  wire bit_end = tick && (cnt == CW'(OSR - 1));
  wire bit_v   = (vs[0] & vs[1]) | (vs[0] & rx_s) | (vs[1] & rx_s);
  wire [3:0] last = nine_bit ? 4'd8 : 4'd7;

  wire full   = (fill == NW'(DEPTH));
  wire pop_ok = rd_pop && (fill != '0);
  wire push   = run && (state == S_STOP) && decide;
  wire accept = push && (!full || pop_ok);

  wire [9:0] entry = {~bit_v,
                      nine_bit ? sh[8] : 1'b0,
                      nine_bit ? sh[7:0] : sh[8:1]};

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_q <= 1'b0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_q <= rx_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      vs    <= '0;
      sh    <= '0;
    end else if (!run) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      if (tick && state != S_IDLE) begin
        cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
        if (cnt == CW'(MID - 1)) vs[0] <= rx_s;
        if (cnt == CW'(MID))     vs[1] <= rx_s;
      end
      case (state)
        S_IDLE:
          if (fall && !ovr_err) begin
            state <= S_START;
            cnt   <= '0;
          end
        S_START:
          if (decide && bit_v) state <= S_IDLE;
          else if (bit_end) begin
            state <= S_DATA;
            idx   <= '0;
          end
        S_DATA: begin
          if (decide) sh <= {bit_v, sh[8:1]};
          if (bit_end) begin
            if (idx == last) state <= S_STOP;
            else idx <= idx + 1'b1;
          end
        end
        S_STOP:
          if (decide) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovr_err <= 1'b0;
    else if (!run) ovr_err <= 1'b0;
    else if (push && full && !pop_ok) ovr_err <= 1'b1;

  always_ff @(posedge clk)
    if (accept) mem[wp] <= entry;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (!port_en) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (accept) wp <= nxt(wp);
      if (pop_ok) rp <= nxt(rp);
      if (accept && !pop_ok) fill <= fill + 1'b1;
      else if (pop_ok && !accept) fill <= fill - 1'b1;
    end

  assign data_avail = (fill != '0);
  assign rd_data    = data_avail ? mem[rp][7:0] : 8'h00;
  assign rd_bit9    = data_avail & mem[rp][8];
  assign rd_ferr    = data_avail & mem[rp][9];
  assign idle       = (state == S_IDLE);
  assign irq        = data_avail & int_en;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic rx_en,
  input logic rd_pop,
  input logic data_avail,
  input logic ovr_err,
  input logic idle
);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && port_en && rx_en |=> ovr_err);

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovr_err);

  assert_ovr_blocks_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> idle);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !data_avail && idle && !ovr_err);

  assert_drain_by_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(rd_pop) || !$past(port_en));

  assert_fill_ends_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> !$past(idle));
endmodule

bind serial_rx_fifo serial_rx_fifo_chk i_chk (.*);

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rxd = 1'b1;
  logic port_en = 1'b0, rx_en = 1'b0, nine_bit = 1'b0, int_en = 1'b0, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, data_avail, ovr_err, idle, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .port_en(port_en),
    .rx_en(rx_en), .nine_bit(nine_bit), .int_en(int_en), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .data_avail(data_avail), .ovr_err(ovr_err), .idle(idle), .irq(irq)
  );

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic play_bit(input logic v, input bit flip8, input bit pop9);
    for (int k = 0; k < 16; k++) begin
      rxd = (flip8 && k == 8) ? ~v : v;
      repeat (3) @(negedge clk);
      tick = 1'b1;
      if (pop9 && k == 9) rd_pop = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      rd_pop = 1'b0;
    end
  endtask

  task automatic line_high();
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic stop_v,
                      input logic [8:0] noisy, input bit pop_at_end);
    play_bit(1'b0, 1'b0, 1'b0);
    for (int b = 0; b < (nine_bit ? 9 : 8); b++) play_bit(d[b], noisy[b], 1'b0);
    play_bit(stop_v, 1'b0, pop_at_end);
    line_high();
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(idle, 1, "R11 idle after reset");
    check(data_avail, 0, "R6 empty after reset");
    check(ovr_err, 0, "R8 no overrun after reset");
    check(irq, 0, "R10 no irq after reset");
    check(rd_data, 0, "R6 data zero when empty");
  endtask

  task automatic t_basic();
    int_en = 1'b1;
    play_bit(1'b0, 1'b0, 1'b0);
    check(idle, 0, "R11 busy during start bit");
    for (int b = 0; b < 8; b++) play_bit(logic'(8'hA5 >> b), 1'b0, 1'b0);
    play_bit(1'b1, 1'b0, 1'b0);
    line_high();
    check(idle, 1, "R11 idle after frame");
    check(data_avail, 1, "R6 avail after frame");
    check(rd_data, 8'hA5, "R1 data byte");
    check(rd_bit9, 0, "R1 ninth bit zero in 8-bit mode");
    check(rd_ferr, 0, "R5 good stop");
    check(irq, 1, "R10 irq with enable");
    int_en = 1'b0;
    @(negedge clk);
    check(irq, 0, "R10 irq masked");
    pop();
    check(data_avail, 0, "R6 empty after pop");
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send(9'h13C, 1'b1, 9'h0, 1'b0);
    check(rd_data, 8'h3C, "R2 byte in 9-bit mode");
    check(rd_bit9, 1, "R2 ninth bit set");
    pop();
    send(9'h0C3, 1'b1, 9'h0, 1'b0);
    check(rd_data, 8'hC3, "R2 byte second frame");
    check(rd_bit9, 0, "R2 ninth bit clear");
    pop();
    nine_bit = 1'b0;
  endtask

  task automatic t_vote();
    send(9'h055, 1'b1, 9'h00B, 1'b0);
    check(rd_data, 8'h55, "R3 majority vote keeps bits");
    pop();
  endtask

  task automatic t_glitch();
    for (int k = 0; k < 16; k++) begin
      rxd = (k < 4) ? 1'b0 : 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
    line_high();
    check(idle, 1, "R4 idle after glitch");
    check(data_avail, 0, "R4 nothing stored for glitch");
  endtask

  task automatic t_frame_err();
    play_bit(1'b0, 1'b0, 1'b0);
    for (int b = 0; b < 8; b++) play_bit(logic'(8'h3C >> b), 1'b0, 1'b0);
    play_bit(1'b0, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    check(idle, 1, "R5 no start while line stays low");
    check(rd_ferr, 1, "R5 framing flag set");
    check(rd_data, 8'h3C, "R5 data kept with framing error");
    line_high();
    pop();
    check(data_avail, 0, "R5 no false frame after low stop");
    send(9'h0E1, 1'b1, 9'h0, 1'b0);
    check(rd_ferr, 0, "R5 framing flag clear on good frame");
    pop();
  endtask

  task automatic t_fifo();
    pop();
    check(data_avail, 0, "R6 pop on empty ignored");
    send(9'h0A1, 1'b1, 9'h0, 1'b0);
    send(9'h0B2, 1'b1, 9'h0, 1'b0);
    check(rd_data, 8'hA1, "R6 first in first out");
    pop();
    check(rd_data, 8'hB2, "R6 second entry");
    pop();
    check(data_avail, 0, "R6 empty after two pops");
  endtask

  task automatic t_overrun();
    send(9'h011, 1'b1, 9'h0, 1'b0);
    send(9'h022, 1'b1, 9'h0, 1'b0);
    send(9'h033, 1'b1, 9'h0, 1'b0);
    check(ovr_err, 1, "R7 overrun on full");
    check(rd_data, 8'h11, "R7 head unchanged by overrun");
    pop();
    send(9'h044, 1'b1, 9'h0, 1'b0);
    check(ovr_err, 1, "R8 overrun sticky");
    check(rd_data, 8'h22, "R7 second entry kept");
    pop();
    check(data_avail, 0, "R8 frame ignored during overrun");
    rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ovr_err, 0, "R8 rx_en low clears overrun");
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    send(9'h055, 1'b1, 9'h0, 1'b0);
    send(9'h066, 1'b1, 9'h0, 1'b0);
    send(9'h077, 1'b1, 9'h0, 1'b1);
    check(ovr_err, 0, "R7 pop with completion avoids overrun");
    check(rd_data, 8'h66, "R7 head after same-cycle pop");
    pop();
    check(rd_data, 8'h77, "R7 third char stored");
    pop();
    check(data_avail, 0, "R7 drained");
  endtask

  task automatic t_enable();
    rx_en = 1'b0;
    send(9'h099, 1'b1, 9'h0, 1'b0);
    check(data_avail, 0, "R9 no reception with rx_en low");
    rx_en = 1'b1;
    send(9'h05A, 1'b1, 9'h0, 1'b0);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(data_avail, 1, "R9 entries kept with rx_en low");
    check(rd_data, 8'h5A, "R9 data kept with rx_en low");
    port_en = 1'b0;
    repeat (2) @(negedge clk);
    check(data_avail, 0, "R9 port_en low flushes");
    port_en = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    port_en = 1'b1;
    rx_en = 1'b1;
    line_high();
    t_basic();
    t_nine();
    t_vote();
    t_glitch();
    t_frame_err();
    t_fifo();
    t_overrun();
    t_same_cycle();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule